// File: doc/BRIEF.md
# Glyph Pixel Rasteriser

This block turns character codes into pixel streams for a display that lacks a hardware character generator. It holds a writable table of monochrome glyph bitmaps. Each glyph is 8 pixels wide and 16 rows tall. For each accepted request, made of a code, a foreground colour and a background colour, the block emits the 128 pixels of that glyph as 16-bit colour words on a valid/ready stream.

Each glyph row is one 16-bit word. The glyph for code `c` takes the 16 consecutive words starting at table address `c*16`, with the top row first. The pixel pattern of a row sits in bits 15..8 of its word: bit 15 is the leftmost column and bit 8 the rightmost. Software fills the table through a plain synchronous write port.

Back-pressure rules are as follows. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. A pixel is consumed on an edge where `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the pixel on offer and its last flag are held unchanged, so no pixel is lost or repeated. The first pixel is offered in the cycle after the request is taken.

Top module: `glyph_raster`

## Requirements
- R1: After reset, `pix_valid` is low and `req_ready` is high.
- R2: While a glyph is being emitted, `req_ready` is low, and a `req_valid` pulse has no effect on the pixels being emitted.
- R3: Each request produces exactly 128 pixels in row-major order: columns left to right within a row, rows top to bottom.
- R4: The pixel for column `k` (0 is leftmost) of row `r` takes bit `15-k` of table word `code*16 + r`.
- R5: A set pattern bit yields the foreground colour, and a clear bit yields the background colour.
- R6: `pix_last` is high on the 128th pixel of a glyph and low on every other pixel.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_data` and `pix_last` stay stable and the offered pixel is not skipped.
- R8: Bits 7..0 of a row word have no effect on the emitted pixels.
- R9: A word written through the load port at the edge where `ld_en` is high is used by every request accepted after that edge.
- R10: In the cycle after the 128th pixel is consumed, `pix_valid` is low and `req_ready` is high.
- R11: Code 0x65, loaded with the lower-case 'e' pattern, yields row 5 as columns 1 to 5 lit and rows 0 to 4 and 12 to 15 fully background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Table write enable |
| ld_addr | input | 12 | Table word address (code*16 + row) |
| ld_data | input | 16 | Row word to store |
| req_valid | input | 1 | Character request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_code | input | 8 | Character code |
| req_fg | input | 16 | Foreground colour |
| req_bg | input | 16 | Background colour |
| pix_valid | output | 1 | Pixel on offer |
| pix_ready | input | 1 | Sink takes the pixel |
| pix_data | output | 16 | Pixel colour |
| pix_last | output | 1 | Final pixel of the glyph |

## Verification
A row or column counter that is off by one shows up as a shifted or swapped colour within the first row. That wrong colour appears at most 8 pixels after the request is accepted. A wrongly timed end of glyph changes where `pix_last` falls and when `req_ready` returns. The bench checks both on every glyph. A stall that lets the walker move is seen in the very next cycle, because the held pixel changes or is skipped. A request that is wrongly taken while busy switches the colours or the glyph on the next pixel.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int ROW_W    = 16;
  localparam int COLS     = 8;
  localparam int ROWS     = 16;
  localparam int COL_BITS = $clog2(COLS);
  localparam int ROW_BITS = $clog2(ROWS);
endpackage

// File: rtl/glyph_store.sv
module glyph_store
  import glyph_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [CODE_W+ROW_BITS-1:0]   waddr,
  input  logic [ROW_W-1:0]             wdata,
  input  logic [CODE_W+ROW_BITS-1:0]   raddr,
  output logic [ROW_W-1:0]             rdata
);
  localparam int DEPTH = (1 << CODE_W) * ROWS;

  logic [ROW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/glyph_walker.sv
module glyph_walker
  import glyph_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int PIX_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CODE_W-1:0]   code_in,
  input  logic [PIX_W-1:0]    fg_in,
  input  logic [PIX_W-1:0]    bg_in,
  input  logic                advance,
  output logic                busy,
  output logic [CODE_W-1:0]   code,
  output logic [PIX_W-1:0]    fg,
  output logic [PIX_W-1:0]    bg,
  output logic [ROW_BITS-1:0] row,
  output logic [COL_BITS-1:0] col,
  output logic                at_end
);
  assign at_end = (row == ROW_BITS'(ROWS - 1)) && (col == COL_BITS'(COLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      code <= '0;
      fg   <= '0;
      bg   <= '0;
      row  <= '0;
      col  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        code <= code_in;
        fg   <= fg_in;
        bg   <= bg_in;
        row  <= '0;
        col  <= '0;
      end
    end else if (advance) begin
      if (at_end) begin
        busy <= 1'b0;
      end else begin
        if (col == COL_BITS'(COLS - 1)) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/glyph_colour.sv
module glyph_colour
  import glyph_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic [ROW_W-1:0]    row_word,
  input  logic [COL_BITS-1:0] col,
  input  logic [PIX_W-1:0]    fg,
  input  logic [PIX_W-1:0]    bg,
  output logic [PIX_W-1:0]    pixel
);
  logic [COLS-1:0] pattern;
  logic            lit;

  assign pattern = row_word[ROW_W-1 -: COLS];
  assign lit     = pattern[~col];
  assign pixel   = lit ? fg : bg;
endmodule

// File: rtl/glyph_raster.sv
module glyph_raster
  import glyph_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int PIX_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [CODE_W+ROW_BITS-1:0] ld_addr,
  input  logic [ROW_W-1:0]           ld_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CODE_W-1:0]          req_code,
  input  logic [PIX_W-1:0]           req_fg,
  input  logic [PIX_W-1:0]           req_bg,
  output logic                       pix_valid,
  input  logic                       pix_ready,
  output logic [PIX_W-1:0]           pix_data,
  output logic                       pix_last
);
  logic                busy;
  logic [CODE_W-1:0]   cur_code;
  logic [PIX_W-1:0]    cur_fg;
  logic [PIX_W-1:0]    cur_bg;
  logic [ROW_BITS-1:0] cur_row;
  logic [COL_BITS-1:0] cur_col;
  logic                at_end;
  logic [ROW_W-1:0]    row_word;

  glyph_walker #(.CODE_W(CODE_W), .PIX_W(PIX_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(req_valid), .code_in(req_code), .fg_in(req_fg), .bg_in(req_bg),
    .advance(pix_ready),
    .busy(busy), .code(cur_code), .fg(cur_fg), .bg(cur_bg),
    .row(cur_row), .col(cur_col), .at_end(at_end)
  );

  glyph_store #(.CODE_W(CODE_W)) u_store (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .raddr({cur_code, cur_row}), .rdata(row_word)
  );

  glyph_colour #(.PIX_W(PIX_W)) u_col (
    .row_word(row_word), .col(cur_col), .fg(cur_fg), .bg(cur_bg),
    .pixel(pix_data)
  );

  assign req_ready = !busy;
  assign pix_valid = busy;
  assign pix_last  = busy && at_end;
endmodule

// File: rtl/glyph_raster_chk.sv
module glyph_raster_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [PIX_W-1:0] pix_data,
  input logic             pix_last
);
  logic [6:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     beats <= '0;
    else if (pix_valid && pix_ready && pix_last)    beats <= '0;
    else if (pix_valid && pix_ready)                beats <= beats + 1'b1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_last));

  // R6
  last_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_last |-> beats == 7'd127);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> pix_valid && !pix_last && !req_ready);

  // R10
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last |=> req_ready && !pix_valid);
endmodule

bind glyph_raster glyph_raster_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .pix_last(pix_last)
);

// File: tb/sim_glyph_raster.sv
module sim_glyph_raster;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_code = '0;
  logic [15:0] req_fg = '0;
  logic [15:0] req_bg = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [15:0] pix_data;
  logic        pix_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] shadow [4096];

  // code[41:34] fg[33:18] bg[17:2] mode[1:0]: 0 free, 1 stalls, 2 stray request
  localparam logic [41:0] VEC [0:5] = '{
    {8'h41, 16'hF800, 16'h001F, 2'd0},
    {8'h00, 16'hFFFF, 16'h0000, 2'd0},
    {8'hFF, 16'h07E0, 16'hAAAA, 2'd1},
    {8'h65, 16'h1234, 16'hFEDC, 2'd1},
    {8'h80, 16'h0F0F, 16'hF0F0, 2'd2},
    {8'h07, 16'h5555, 16'h3333, 2'd0}
  };

  glyph_raster u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(int code, int row);
    logic [7:0] e_rows [16] = '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h7C,8'hC6,8'hC6,
                                8'hFE,8'hC0,8'hC6,8'h7C,8'h00,8'h00,8'h00,8'h00};
    if (code == 8'h65) return {e_rows[row], 8'h00};
    return {8'((code * 29) ^ (row * 53) ^ (row << 4)), 8'((code + row) | 8'h81)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int addr, logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 12'(addr); ld_data = d;
    shadow[addr] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic render(logic [7:0] code, logic [15:0] fg, logic [15:0] bg, int mode);
    logic [15:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_code = code; req_fg = fg; req_bg = bg;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 128; i++) begin
      logic [15:0] w;
      w = shadow[int'(code) * 16 + i / 8];
      exp = w[15 - (i % 8)] ? fg : bg;
      // R3 R4 R5
      check(pix_valid && pix_data == exp, "R3/R4/R5 pixel", {15'd0, pix_valid, pix_data}, {16'd1, exp});
      // R6
      check(pix_last == (i == 127), "R6 last", 32'(pix_last), 32'(i == 127));
      if (mode == 2 && i == 60) begin
        // R2
        check(!req_ready, "R2 ready busy", 32'(req_ready), 32'd0);
        req_valid = 1'b1; req_code = code + 8'd1; req_fg = ~fg; req_bg = ~bg;
      end
      if (mode == 1 && (i % 3 == 1)) begin
        pix_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R7
        check(pix_valid && pix_data == exp && pix_last == (i == 127), "R7 hold",
              {15'd0, pix_valid, pix_data}, {16'd1, exp});
      end
      pix_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      pix_ready = 1'b0;
    end
    // R10
    check(!pix_valid && req_ready, "R10 idle", {pix_valid, req_ready}, 32'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    // R1
    check(!pix_valid && req_ready, "R1 reset", {pix_valid, req_ready}, 32'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pix_valid && req_ready, "R1 after release", {pix_valid, req_ready}, 32'b01);
    for (int a = 0; a < 4096; a++) begin
      ld_en = 1'b1; ld_addr = 12'(a); ld_data = pat(a / 16, a % 16);
      shadow[a] = ld_data;
      @(negedge clk);
    end
    ld_en = 1'b0;
    for (int v = 0; v < 6; v++)
      render(VEC[v][41:34], VEC[v][33:18], VEC[v][17:2], int'(VEC[v][1:0]));
    // R11: 'e' row 5 = 0x7C -> cols 1..5 lit
    check(shadow[16'h65 * 16 + 5] == 16'h7C00, "R11 e row", 32'(shadow[16'h65*16+5]), 32'h7C00);
    // R8: same pattern, different low byte, same pixels
    load(16'h33 * 16 + 2, 16'hA5FF);
    load(16'h33 * 16 + 3, 16'hA500);
    render(8'h33, 16'hC0DE, 16'h0BAD, 0);
    // R9: rewrite then render
    load(7 * 16 + 3, 16'h8100);
    load(7 * 16 + 15, 16'hFF3C);
    render(8'h07, 16'h1111, 16'h2222, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule